// File: doc/BRIEF.md
# MDIO Single-Command Management Controller

This block is an MDIO bus master controlled through a small 32-bit register port. Software first waits until the busy flag in the control register reads zero. For a write, it loads the 16-bit payload into the low half of the transfer register. It then writes one control word that carries the busy bit, one operation bit, a PHY address and a register number. The block generates one Clause 22 management frame on the MDC and MDIO pins and clears busy when the frame has finished.

For a read, the block releases MDIO from the turnaround onward. It shifts in the sixteen bits the PHY returns and places them in the upper half of the transfer register. A separate flag register records whether the PHY failed to pull the second turnaround bit low, so software can tell that the returned value is not valid. MDC comes from the system clock divided by a parameter, and MDC stays low whenever no frame is in progress.

Register map: word 0 is the control register, word 1 is the transfer register and word 2 is the flag register. Reads are combinational from `reg_addr`.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset, busy is 0, MDC is low, the MDIO output enable is 0, and all three registers read as zero.
- R2: A write to the control register while idle starts a frame when it meets two conditions: bit 20 (busy) is set, and exactly one of bit 17 (read) or bit 16 (write) is set. Busy reads as 1 from the next cycle. The control register then reads back bit 20 as busy, bits 17 and 16 as the issued operation, bits 12:8 as the PHY address and bits 4:0 as the register number.
- R3: A control word without bit 20, or with both or neither of bits 17 and 16, starts nothing. Busy stays 0 and MDC does not toggle.
- R4: A control word written while busy is 1 is ignored. The frame in progress and the control register readback keep the values of the first command, and no second frame follows.
- R5: A write frame carries, MSB first: 32 ones, start bits 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10, and bits 15:0 of the transfer register. MDIO is driven for all 64 bits.
- R6: A read frame uses opcode 10. The block drives MDIO only for the first 46 bits and releases it from the first turnaround bit to the end of the frame.
- R7: Each MDC half period lasts DIV_HALF system clocks. MDIO output bits change only when MDC falls, and input bits are sampled when MDC rises. Busy clears at the MDC fall that ends bit 64, exactly 128*DIV_HALF cycles after the command is accepted. MDC is low whenever busy is 0.
- R8: When a read completes, the 16 bits sampled on rising MDC edges (first bit as MSB) appear in bits 31:16 of the transfer register. Bits 15:0 keep the value software last wrote.
- R9: Flag register bit 0 takes, at the end of each read, the level sampled on the second turnaround bit: 1 means invalid data. Write frames leave the flag unchanged.
- R10: Writes to the transfer register set bits 15:0, which read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest case to reach is a turnaround on which the PHY fails to pull the line low. This can only happen during one MDC high phase deep inside a read frame. The bench's PHY model follows the falling edges of MDC and chooses, per frame, the level it presents on that bit. As a result, an invalid read, a valid read that clears the flag, and a write that must leave the flag alone can run back to back. A command issued in the middle of a frame is also injected a few cycles after the start, and the bench then compares the whole captured frame against the first command's fields.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int PHY_W    = 5;
   localparam int REGN_W   = 5;
   localparam int DATA_W   = 16;
   localparam int BUSY_BIT = 20;
   localparam int RD_BIT   = 17;
   localparam int WR_BIT   = 16;
   localparam int PHY_LSB  = 8;
   localparam int REGN_LSB = 0;

   localparam logic [1:0] A_CTL  = 2'd0;
   localparam logic [1:0] A_XFER = 2'd1;
   localparam logic [1:0] A_FLAG = 2'd2;

   typedef struct packed {
      logic              op_rd;
      logic              op_wr;
      logic [PHY_W-1:0]  phy;
      logic [REGN_W-1:0] regn;
   } mdio_cmd_t;
endpackage

// File: rtl/mdc_clock_gen.sv
module mdc_clock_gen #(
   parameter int DIV_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise,
   output logic fall
);
   logic tick;

   generate
      if (DIV_HALF < 1) begin : g_bad
         $error("DIV_HALF must be at least 1");
      end
      if (DIV_HALF == 1) begin : g_nodiv
         assign tick = run;
      end else begin : g_div
         localparam int CNT_W = $clog2(DIV_HALF);
         localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt <= '0;
            else if (!run)           cnt <= '0;
            else if (cnt == CNT_LAST) cnt <= '0;
            else                     cnt <= cnt + 1'b1;
         end
         assign tick = run && (cnt == CNT_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mdc <= 1'b0;
      else if (!run) mdc <= 1'b0;
      else if (tick) mdc <= ~mdc;
   end

   assign rise = tick && !mdc;
   assign fall = tick && mdc;

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise && fall)); // R7
   AST_STROBE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (rise || fall) |-> run); // R7
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
   import mdio_pkg::*;
#(
   parameter int PREAMBLE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  mdio_cmd_t         cmd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rise,
   input  logic              fall,
   input  logic              mdio_i,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              ta_bad
);
   localparam int FRAME_LEN = PREAMBLE_LEN + 4 + PHY_W + REGN_W + 2 + DATA_W;
   localparam int IDX_W     = $clog2(FRAME_LEN);
   localparam int TA_POS    = PREAMBLE_LEN + 4 + PHY_W + REGN_W;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);
   localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_POS);
   localparam logic [IDX_W-1:0] IDX_TA2  = IDX_W'(TA_POS + 1);
   localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(TA_POS + 2);

   generate
      if (PREAMBLE_LEN < 1 || PREAMBLE_LEN > 64) begin : g_bad
         $error("PREAMBLE_LEN out of range");
      end
   endgenerate

   logic                 active;
   logic                 is_rd;
   logic [IDX_W-1:0]     idx;
   logic [FRAME_LEN-1:0] sh;
   logic [FRAME_LEN-1:0] frame_img;

   assign frame_img = {{PREAMBLE_LEN{1'b1}}, 2'b01, cmd.op_rd, cmd.op_wr,
                       cmd.phy, cmd.regn, 2'b10, wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         is_rd   <= 1'b0;
         idx     <= '0;
         sh      <= '0;
         rd_data <= '0;
         ta_bad  <= 1'b0;
      end else if (start) begin
         active  <= 1'b1;
         is_rd   <= cmd.op_rd;
         idx     <= '0;
         sh      <= frame_img;
         rd_data <= '0;
         ta_bad  <= 1'b0;
      end else if (active) begin
         if (rise) begin
            if (idx == IDX_TA2)  ta_bad  <= mdio_i;
            if (idx >= IDX_DATA) rd_data <= {rd_data[DATA_W-2:0], mdio_i};
         end
         if (fall) begin
            if (idx == IDX_LAST) begin
               active <= 1'b0;
            end else begin
               idx <= idx + 1'b1;
               sh  <= {sh[FRAME_LEN-2:0], 1'b0};
            end
         end
      end
   end

   assign done    = active && fall && (idx == IDX_LAST);
   assign mdio_o  = active && sh[FRAME_LEN-1];
   assign mdio_oe = active && !(is_rd && idx >= IDX_TA);

   AST_OUT_HOLDS_UNTIL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !fall) |=> $stable(mdio_o)); // R7
   AST_OE_OFF_AFTER_READ_TA: assert property (@(posedge clk) disable iff (!rst_n)
      (active && is_rd && fall && idx == IDX_TA2) |=> !mdio_oe); // R6
   AST_NO_START_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> !start); // R4
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
   import mdio_pkg::*;
#(
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              done,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              ta_bad,
   output logic              start,
   output mdio_cmd_t         cmd_q,
   output logic [DATA_W-1:0] wr_hold,
   output logic              busy
);
   generate
      if (ADDR_W < 2) begin : g_bad
         $error("ADDR_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] rd_hold;
   logic              bad_q;
   logic              sel_ctl, sel_xfer, cmd_ok;

   assign sel_ctl  = reg_addr == ADDR_W'(A_CTL);
   assign sel_xfer = reg_addr == ADDR_W'(A_XFER);
   assign cmd_ok   = reg_wdata[BUSY_BIT] && (reg_wdata[RD_BIT] ^ reg_wdata[WR_BIT]);
   assign start    = reg_wr && sel_ctl && !busy && cmd_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cmd_q   <= '0;
         wr_hold <= '0;
         rd_hold <= '0;
         bad_q   <= 1'b0;
      end else begin
         if (start) begin
            busy        <= 1'b1;
            cmd_q.op_rd <= reg_wdata[RD_BIT];
            cmd_q.op_wr <= reg_wdata[WR_BIT];
            cmd_q.phy   <= reg_wdata[PHY_LSB +: PHY_W];
            cmd_q.regn  <= reg_wdata[REGN_LSB +: REGN_W];
         end else if (done) begin
            busy <= 1'b0;
            if (cmd_q.op_rd) begin
               rd_hold <= rd_data;
               bad_q   <= ta_bad;
            end
         end
         if (reg_wr && sel_xfer) wr_hold <= reg_wdata[DATA_W-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(A_CTL): begin
            reg_rdata[BUSY_BIT]                  = busy;
            reg_rdata[RD_BIT]                    = cmd_q.op_rd;
            reg_rdata[WR_BIT]                    = cmd_q.op_wr;
            reg_rdata[PHY_LSB +: PHY_W]          = cmd_q.phy;
            reg_rdata[REGN_LSB +: REGN_W]        = cmd_q.regn;
         end
         ADDR_W'(A_XFER): reg_rdata = {rd_hold, wr_hold};
         ADDR_W'(A_FLAG): reg_rdata[0] = bad_q;
         default:         reg_rdata = '0;
      endcase
   end

   AST_CMD_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cmd_q)); // R4
   AST_BUSY_FROM_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(reg_wr) && $past(reg_addr) == ADDR_W'(A_CTL))); // R2
   AST_DONE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy); // R7
   AST_FLAG_MOVES_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bad_q) |-> ($past(done) && $past(cmd_q.op_rd))); // R9
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
   import mdio_pkg::*;
#(
   parameter int DIV_HALF     = 2,
   parameter int PREAMBLE_LEN = 32,
   parameter int ADDR_W       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   logic              start, done, busy, rise, fall, ta_bad;
   mdio_cmd_t         cmd_q;
   logic [DATA_W-1:0] wr_hold, rd_data;

   mdio_host_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done),
      .rd_data(rd_data), .ta_bad(ta_bad), .start(start), .cmd_q(cmd_q),
      .wr_hold(wr_hold), .busy(busy)
   );

   mdc_clock_gen #(.DIV_HALF(DIV_HALF)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(busy), .mdc(mdc), .rise(rise), .fall(fall)
   );

   mdio_cmd_t cmd_next;
   assign cmd_next = '{op_rd: reg_wdata[RD_BIT], op_wr: reg_wdata[WR_BIT],
                       phy:   reg_wdata[PHY_LSB +: PHY_W],
                       regn:  reg_wdata[REGN_LSB +: REGN_W]};

   mdio_frame_shifter #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd_next),
      .wdata(wr_hold), .rise(rise), .fall(fall), .mdio_i(mdio_i),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done), .rd_data(rd_data),
      .ta_bad(ta_bad)
   );

   AST_MDC_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc); // R7
   AST_BUSY_ENDS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(fall)); // R7
   AST_OE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> busy); // R1
endmodule

// File: tb/test_mdio_cmd_master.sv
module test_mdio_cmd_master;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 2;
   localparam int FRAME_CYC  = 128 * DIV;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int n_checks = 0;
   int n_fail   = 0;

   mdio_cmd_master #(.DIV_HALF(DIV), .PREAMBLE_LEN(32), .ADDR_W(2)) i_mdio_cmd_master (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // PHY model
   logic        clr = 1'b0;
   logic [63:0] cap;
   int          fall_cnt, rise_cnt, oe_cnt;
   logic [15:0] phy_val = '0;
   logic        ta_drive = 1'b0;

   always @(posedge mdc or negedge mdc or posedge clr) begin
      if (clr) begin
         cap = '0; fall_cnt = 0; rise_cnt = 0; oe_cnt = 0; mdio_i = 1'b1;
      end else if (mdc) begin
         cap = {cap[62:0], mdio_oe ? mdio_o : 1'b1};
         rise_cnt++;
         if (mdio_oe) oe_cnt++;
      end else begin
         fall_cnt++;
         if (fall_cnt == 47)                      mdio_i = ta_drive;
         else if (fall_cnt >= 48 && fall_cnt < 64) mdio_i = phy_val[63 - fall_cnt];
         else                                     mdio_i = 1'b1;
      end
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   function automatic logic [31:0] ctl_word(input bit rd, input logic [4:0] p,
                                            input logic [4:0] r);
      return (32'd1 << 20) | (rd ? (32'd1 << 17) : (32'd1 << 16)) |
             ({27'd0, p} << 8) | {27'd0, r};
   endfunction

   task automatic pulse_clr();
      clr = 1'b1; #1; clr = 1'b0;
   endtask

   // Waits while busy; returns number of negedge samples with busy set.
   task automatic wait_idle(output int n);
      logic [31:0] v;
      n = 0;
      for (int k = 0; k < 5000; k++) begin
         reg_read(2'd0, v);
         if (!v[20]) break;
         n++;
         @(negedge clk);
      end
   endtask

   task automatic do_frame(input bit rd, input logic [4:0] p, input logic [4:0] r,
                           input string tag);
      logic [31:0] v;
      int n;
      pulse_clr();
      reg_write(2'd0, ctl_word(rd, p, r));
      reg_read(2'd0, v);
      check(v == ctl_word(rd, p, r), "R2", {32'd0, v}, {32'd0, ctl_word(rd, p, r)});
      wait_idle(n);
      check(n == FRAME_CYC, "R7", n, FRAME_CYC);
      reg_read(2'd0, v);
      check(v == (ctl_word(rd, p, r) & ~(32'd1 << 20)), "R2", {32'd0, v},
            {32'd0, ctl_word(rd, p, r) & ~(32'd1 << 20)});
      check(rise_cnt == 64, {"R7 ", tag}, rise_cnt, 64);
   endtask

   initial begin
      logic [31:0] v;
      logic [63:0] exp;
      logic [15:0] wd;
      logic [4:0]  p, r;
      int n;

      repeat (3) @(negedge clk);
      // R1 reset state
      check(mdc == 1'b0 && mdio_oe == 1'b0, "R1", {mdc, mdio_oe}, 0);
      for (int a = 0; a < 3; a++) begin
         reg_read(a[1:0], v);
         check(v == 0, "R1", v, 0);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R10 transfer register low half
      reg_write(2'd1, 32'hDEAD_5A3C);
      reg_read(2'd1, v);
      check(v == 32'h0000_5A3C, "R10", v, 32'h0000_5A3C);

      // R5 write sweep
      for (int i = 0; i < 6; i++) begin
         p  = 5'((i * 13 + (i == 5 ? 31 : 0)) & 31);
         r  = 5'(31 - i * 6);
         wd = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : 16'((i * 16'h3A71) ^ 16'hA5A5);
         reg_write(2'd1, {16'h0, wd});
         do_frame(1'b0, p, r, "write");
         exp = {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, wd};
         check(cap == exp, "R5", cap, exp);
         check(oe_cnt == 64, "R5", oe_cnt, 64);
      end

      // R6/R8/R9 read sweep
      reg_write(2'd1, 32'h0000_1234);
      for (int i = 0; i < 6; i++) begin
         p = 5'(i * 5 + 1);
         r = 5'(i * 7);
         phy_val  = (i == 0) ? 16'hFFFF : (i == 1) ? 16'h0001 : 16'((i * 16'h1F3D) ^ 16'h8000);
         ta_drive = (i == 3);
         do_frame(1'b1, p, r, "read");
         exp = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 18'h3FFFF};
         check(cap == exp, "R6", cap, exp);
         check(oe_cnt == 46, "R6", oe_cnt, 46);
         reg_read(2'd1, v);
         check(v == {phy_val, 16'h1234}, "R8", v, {phy_val, 16'h1234});
         reg_read(2'd2, v);
         check(v == {31'd0, ta_drive}, "R9", v, {31'd0, ta_drive});
      end

      // R9 invalid read, then a write leaves the flag, then a good read clears it
      phy_val = 16'hBEEF; ta_drive = 1'b1;
      do_frame(1'b1, 5'd2, 5'd3, "read");
      reg_read(2'd2, v);
      check(v == 32'd1, "R9", v, 1);
      ta_drive = 1'b0;
      do_frame(1'b0, 5'd4, 5'd5, "write");
      reg_read(2'd2, v);
      check(v == 32'd1, "R9", v, 1);
      do_frame(1'b1, 5'd6, 5'd7, "read");
      reg_read(2'd2, v);
      check(v == 32'd0, "R9", v, 0);

      // R3 malformed commands
      pulse_clr();
      reg_write(2'd0, 32'h0013_0101);
      repeat (4 * DIV) @(negedge clk);
      reg_read(2'd0, v);
      check(v[20] == 1'b0 && rise_cnt == 0, "R3", {v[20], 8'(rise_cnt)}, 0);
      reg_write(2'd0, 32'h0001_0101);
      reg_write(2'd0, 32'h0010_0101);
      repeat (4 * DIV) @(negedge clk);
      reg_read(2'd0, v);
      check(v[20] == 1'b0 && rise_cnt == 0, "R3", {v[20], 8'(rise_cnt)}, 0);

      // R4 command during busy ignored
      reg_write(2'd1, 32'h0000_C3A5);
      pulse_clr();
      reg_write(2'd0, ctl_word(1'b0, 5'd9, 5'd17));
      repeat (5) @(negedge clk);
      reg_write(2'd0, ctl_word(1'b1, 5'd22, 5'd4));
      wait_idle(n);
      exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd9, 5'd17, 2'b10, 16'hC3A5};
      check(cap == exp, "R4", cap, exp);
      reg_read(2'd0, v);
      check(v == (ctl_word(1'b0, 5'd9, 5'd17) & ~(32'd1 << 20)), "R4", v,
            ctl_word(1'b0, 5'd9, 5'd17) & ~(32'd1 << 20));
      repeat (FRAME_CYC) @(negedge clk);
      reg_read(2'd0, v);
      check(v[20] == 1'b0 && rise_cnt == 64, "R4", {v[20], 8'(rise_cnt)}, 64);
      check(mdc == 1'b0, "R7", mdc, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule